// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is a serial slave on a two-wire bus (clock line plus open-drain data line). It gives a host read and write access to six 8-bit control registers. The host can move one register per transaction, or move a run of registers in one transaction that starts at register 0. Every byte on the wire travels most significant bit first.

The bus lines come in as plain inputs and are oversampled by the system clock. The data output is an enable: when it is high, the pad pulls the line low. Three bits of the register bank are exported as control outputs: a clock output enable, a spread-spectrum enable, and a spread-depth select.

After the address byte, the host sends a command byte. Bit 7 of the command byte picks single-register mode (1) or run mode (0). Bits 6:5 must be zero. Bits 4:0 hold the register index in single-register mode and must be zero in run mode. A run write places a count byte ahead of its data. A run read returns a count byte ahead of the registers.

Top module: `smb_ctl_slave`

## Requirements
- R1: The slave acknowledges only the address byte 0xD2 for writes or 0xD3 for reads (7-bit address 0x69, bit 0 = 1 for read). After any other address it neither acknowledges nor drives the data line until the next start condition.
- R2: Command byte bit 7 = 1 selects single-register mode and bit 7 = 0 selects run mode. The command is acknowledged only when bits 6:5 are 00, and bits 4:0 are in the range 0..5 (single-register mode) or exactly 00000 (run mode). A rejected command is not acknowledged, and the bytes that follow it are neither acknowledged nor written.
- R3: Single-register write: the data byte after the command is stored at the register index and acknowledged. Any further data byte in the same transaction is not acknowledged and not stored.
- R4: Single-register read: after a repeated start and address 0xD3, the slave returns the indexed register MSB first. It pulls the data line low only for 0 bits.
- R5: Run write: the count byte is acknowledged and its value is not used. Data bytes are then stored into register 0, 1, 2 and so on. A data byte aimed beyond register 5 is not acknowledged and is discarded.
- R6: Run read: after address 0xD3, the slave returns the value 6 first, then registers 0 to 5 in order. Any byte requested after register 5 reads as 0xFF, because the slave leaves the line released.
- R7: Reset loads registers 0..5 with 0x3C, 0x00, 0xEB, 0xAF, 0x01 and 0x00, and releases the data line.
- R8: out_en_o follows register 0 bit 2 (0 = output off). spread_en_o follows register 2 bit 2 (1 = spread on). spread_sel_o follows register 2 bit 7 (0 = -0.35 %, 1 = -0.5 %). They change only through register writes.
- R9: A start or stop condition seen at any point drops a partly received byte and releases the data line. A start then expects a fresh address byte.
- R10: The slave only begins pulling the data line low while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, raw |
| sda_i | input | 1 | Bus data line, raw |
| sda_oe_o | output | 1 | When high, the data line is pulled low |
| out_en_o | output | 1 | Clock output enable (register 0 bit 2) |
| spread_en_o | output | 1 | Spread-spectrum enable (register 2 bit 2) |
| spread_sel_o | output | 1 | Spread depth select (register 2 bit 7) |

## Verification
The checker assumes that each level of the clock line lasts several system clocks, so the three-flop sampler sees every edge. It also assumes that the host moves the data line while the clock line is high only to make a start or a stop. The bench holds every quarter of a bit period for five system clocks. It changes the data line one quarter after the clock falls, so the slave's own response to a falling edge settles before the host samples. Stimulus that breaks these rules is left out on purpose, except for the start and stop conditions placed in the middle of a byte. Those are legal line events, and R9 covers them.

// File: rtl/smb_ctl_pkg.sv
package smb_ctl_pkg;

    // Bit-level phase of the serial engine
    typedef enum logic [2:0] {
        PH_IDLE,   // waiting for a start condition
        PH_RX,     // shifting in a byte from the host
        PH_ACK,    // slave acknowledge slot
        PH_TX,     // shifting out a byte to the host
        PH_MACK    // host acknowledge slot
    } phase_e;

    // Meaning of the byte currently being received
    typedef enum logic [1:0] {
        RL_ADDR,
        RL_CMD,
        RL_CNT,
        RL_DATA
    } role_e;

    localparam int BYTE_BITS = 8;

endpackage

// File: rtl/smb_ctl_sync.sv
module smb_ctl_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    // two synchronizing stages plus one history stage per line
    typedef struct packed {
        logic [2:0] scl;
        logic [2:0] sda;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d.scl = {smp_q.scl[1:0], scl_i};
        smp_d.sda = {smp_q.sda[1:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '1;
        else        smp_q <= smp_d;
    end

    assign scl_s    = smp_q.scl[1];
    assign sda_s    = smp_q.sda[1];
    assign scl_rise =  smp_q.scl[1] & ~smp_q.scl[2];
    assign scl_fall = ~smp_q.scl[1] &  smp_q.scl[2];
    assign start_ev =  smp_q.scl[1] & smp_q.scl[2] &  smp_q.sda[2] & ~smp_q.sda[1];
    assign stop_ev  =  smp_q.scl[1] & smp_q.scl[2] & ~smp_q.sda[2] &  smp_q.sda[1];

endmodule

// File: rtl/smb_ctl_regs.sv
module smb_ctl_regs #(
    parameter int              NREG       = 6,
    parameter int              PTR_W      = 4,
    parameter logic [NREG*8-1:0] RST_VAL  = 48'h00_01_AF_EB_00_3C,
    parameter int              OE_REG     = 0,
    parameter int              OE_BIT     = 2,
    parameter int              SS_REG     = 2,
    parameter int              SS_EN_BIT  = 2,
    parameter int              SS_SEL_BIT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wen,
    input  logic [PTR_W-1:0] waddr,
    input  logic [7:0]       wdata,
    input  logic [PTR_W-1:0] raddr,
    output logic [7:0]       rdata,
    output logic             out_en,
    output logic             spread_en,
    output logic             spread_sel
);
    logic [7:0] regs_d [NREG];
    logic [7:0] regs_q [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            regs_d[i] = (wen && waddr == PTR_W'(i)) ? wdata : regs_q[i];
        end
    end

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) regs_q[g] <= RST_VAL[g*8 +: 8];
                else        regs_q[g] <= regs_d[g];
            end
        end
    endgenerate

    // read mux: indices beyond the bank read as a released line
    always_comb begin
        rdata = 8'hFF;
        for (int i = 0; i < NREG; i++) begin
            if (raddr == PTR_W'(i)) rdata = regs_q[i];
        end
    end

    assign out_en     = regs_q[OE_REG][OE_BIT];
    assign spread_en  = regs_q[SS_REG][SS_EN_BIT];
    assign spread_sel = regs_q[SS_REG][SS_SEL_BIT];

endmodule

// File: rtl/smb_ctl_fsm.sv
module smb_ctl_fsm
    import smb_ctl_pkg::*;
#(
    parameter int         NREG     = 6,
    parameter int         PTR_W    = 4,
    parameter logic [6:0] SLV_ADDR = 7'h69
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_ev,
    input  logic             stop_ev,
    input  logic [7:0]       rd_data,
    output logic [PTR_W-1:0] rd_addr,
    output logic             wen,
    output logic [PTR_W-1:0] waddr,
    output logic [7:0]       wdata,
    output logic             sda_oe
);
    localparam logic [PTR_W-1:0] NREG_P = PTR_W'(NREG);
    localparam logic [4:0]       NREG_5 = 5'(NREG);
    localparam logic [3:0]       FULL   = 4'(BYTE_BITS);

    typedef struct packed {
        phase_e           ph;
        role_e            role;
        logic [3:0]       bitc;
        logic [7:0]       sh;
        logic             blk;
        logic [PTR_W-1:0] ptr;
        logic             cnt_pend;
        logic             tx_next;
        logic             mnack;
        logic             drive;
        logic             wen;
        logic [PTR_W-1:0] waddr;
        logic [7:0]       wdata;
    } st_t;

    st_t q, n;
    logic             acc;
    logic [7:0]       tx_byte;
    logic [PTR_W-1:0] tx_ptr;

    // next byte to send: count first in run reads, then registers, then 0xFF
    always_comb begin
        tx_byte = 8'hFF;
        tx_ptr  = q.ptr;
        if (q.cnt_pend) begin
            tx_byte = 8'(NREG);
        end else if (q.ptr < NREG_P) begin
            tx_byte = rd_data;
            tx_ptr  = q.ptr + PTR_W'(1);
        end
    end

    always_comb begin
        n     = q;
        n.wen = 1'b0;
        acc   = 1'b0;
        if (stop_ev) begin
            n.ph    = PH_IDLE;
            n.drive = 1'b0;
            n.blk   = 1'b0;
            n.ptr   = '0;
        end else if (start_ev) begin
            n.ph    = PH_RX;
            n.role  = RL_ADDR;
            n.bitc  = '0;
            n.drive = 1'b0;
        end else begin
            unique case (q.ph)
                PH_RX: begin
                    if (scl_rise) begin
                        n.sh   = {q.sh[6:0], sda_s};
                        n.bitc = q.bitc + 4'd1;
                    end else if (scl_fall && q.bitc == FULL) begin
                        unique case (q.role)
                            RL_ADDR: if (q.sh[7:1] == SLV_ADDR) begin
                                acc        = 1'b1;
                                n.tx_next  = q.sh[0];
                                n.cnt_pend = q.sh[0] & q.blk;
                                n.role     = RL_CMD;
                            end
                            RL_CMD: if (q.sh[6:5] == 2'b00 &&
                                        (q.sh[7] ? (q.sh[4:0] < NREG_5) : (q.sh[4:0] == 5'd0))) begin
                                acc    = 1'b1;
                                n.blk  = ~q.sh[7];
                                n.ptr  = q.sh[7] ? PTR_W'(q.sh[4:0]) : '0;
                                n.role = q.sh[7] ? RL_DATA : RL_CNT;
                            end
                            RL_CNT: begin
                                acc    = 1'b1;
                                n.role = RL_DATA;
                            end
                            RL_DATA: if (q.ptr < NREG_P) begin
                                acc     = 1'b1;
                                n.wen   = 1'b1;
                                n.waddr = q.ptr;
                                n.wdata = q.sh;
                                n.ptr   = q.blk ? q.ptr + PTR_W'(1) : '1;
                            end
                            default: ;
                        endcase
                        n.ph    = acc ? PH_ACK : PH_IDLE;
                        n.drive = acc;
                    end
                end
                PH_ACK: if (scl_fall) begin
                    n.bitc = '0;
                    if (q.tx_next) begin
                        n.ph       = PH_TX;
                        n.sh       = tx_byte;
                        n.ptr      = tx_ptr;
                        n.cnt_pend = 1'b0;
                        n.drive    = ~tx_byte[7];
                    end else begin
                        n.ph    = PH_RX;
                        n.drive = 1'b0;
                    end
                end
                PH_TX: begin
                    if (scl_rise) begin
                        n.bitc = q.bitc + 4'd1;
                    end else if (scl_fall) begin
                        if (q.bitc == FULL) begin
                            n.ph    = PH_MACK;
                            n.drive = 1'b0;
                        end else begin
                            n.sh    = {q.sh[6:0], 1'b0};
                            n.drive = ~q.sh[6];
                        end
                    end
                end
                PH_MACK: begin
                    if (scl_rise) begin
                        n.mnack = sda_s;
                    end else if (scl_fall) begin
                        if (q.mnack) begin
                            n.ph = PH_IDLE;
                        end else begin
                            n.ph       = PH_TX;
                            n.bitc     = '0;
                            n.sh       = tx_byte;
                            n.ptr      = tx_ptr;
                            n.cnt_pend = 1'b0;
                            n.drive    = ~tx_byte[7];
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign rd_addr = q.ptr;
    assign wen     = q.wen;
    assign waddr   = q.waddr;
    assign wdata   = q.wdata;
    assign sda_oe  = q.drive;

endmodule

// File: rtl/smb_ctl_slave.sv
module smb_ctl_slave #(
    parameter int                NREG     = 6,
    parameter logic [6:0]        SLV_ADDR = 7'h69,
    parameter logic [NREG*8-1:0] RST_VAL  = 48'h00_01_AF_EB_00_3C
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe_o,
    output logic out_en_o,
    output logic spread_en_o,
    output logic spread_sel_o
);
    localparam int PTR_W = $clog2(NREG) + 1;

    logic             scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic             wen;
    logic [PTR_W-1:0] waddr, rd_addr;
    logic [7:0]       wdata, rd_data;

    smb_ctl_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    smb_ctl_fsm #(
        .NREG     (NREG),
        .PTR_W    (PTR_W),
        .SLV_ADDR (SLV_ADDR)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .wen      (wen),
        .waddr    (waddr),
        .wdata    (wdata),
        .sda_oe   (sda_oe_o)
    );

    smb_ctl_regs #(
        .NREG    (NREG),
        .PTR_W   (PTR_W),
        .RST_VAL (RST_VAL)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wen        (wen),
        .waddr      (waddr),
        .wdata      (wdata),
        .raddr      (rd_addr),
        .rdata      (rd_data),
        .out_en     (out_en_o),
        .spread_en  (spread_en_o),
        .spread_sel (spread_sel_o)
    );

endmodule

// File: rtl/smb_ctl_chk.sv
module smb_ctl_chk #(
    parameter int NREG  = 6,
    parameter int PTR_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_s,
    input logic             start_ev,
    input logic             stop_ev,
    input logic             wen,
    input logic [PTR_W-1:0] waddr,
    input logic             sda_oe_o,
    input logic             out_en_o,
    input logic             spread_en_o,
    input logic             spread_sel_o
);
    AST_RESET_DEFAULTS: assert property (@(posedge clk)
        !rst_n |=> (out_en_o && !spread_en_o && spread_sel_o && !sda_oe_o)); // R7

    AST_PULL_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_s); // R10

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_oe_o); // R9

    AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> !sda_oe_o); // R9

    AST_WRITE_IN_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        wen |-> (waddr < PTR_W'(NREG))); // R5

    AST_CTRL_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wen |=> $stable({out_en_o, spread_en_o, spread_sel_o})); // R8

endmodule

bind smb_ctl_slave smb_ctl_chk #(
    .NREG  (NREG),
    .PTR_W (PTR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_s        (scl_s),
    .start_ev     (start_ev),
    .stop_ev      (stop_ev),
    .wen          (wen),
    .waddr        (waddr),
    .sda_oe_o     (sda_oe_o),
    .out_en_o     (out_en_o),
    .spread_en_o  (spread_en_o),
    .spread_sel_o (spread_sel_o)
);

// File: tb/smb_ctl_slave_tb.sv
module smb_ctl_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 5;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic scl   = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_oe, out_en, spread_en, spread_sel;

    int errors = 0;
    int checks = 0;
    int mdl [6];
    bit cmp_en = 1'b0;
    int scl_hi = 0;
    logic prev_oe = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    smb_ctl_slave u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl),
        .sda_i        (sda_line),
        .sda_oe_o     (sda_oe),
        .out_en_o     (out_en),
        .spread_en_o  (spread_en),
        .spread_sel_o (spread_sel)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_ctrl();
        return (((mdl[0] >> 2) & 1) << 2) | (((mdl[2] >> 2) & 1) << 1) | ((mdl[2] >> 7) & 1);
    endfunction

    // per-clock reference comparison of the exported bits and the drive rule
    always @(negedge clk) begin
        if (scl) scl_hi++;
        else     scl_hi = 0;
        if (rst_n && cmp_en)
            chk({out_en, spread_en, spread_sel} == 3'(exp_ctrl()), "R8 ctrl outputs",
                int'({out_en, spread_en, spread_sel}), exp_ctrl());
        if (rst_n && scl_hi >= 2)
            chk(!(sda_oe && !prev_oe), "R10 pull started with clock high", int'(sda_oe), 0);
        prev_oe = sda_oe;
    end

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic start_c();
        sda_m = 1'b1; wait_q(); scl = 1'b1; wait_q();
        sda_m = 1'b0; wait_q(); scl = 1'b0; wait_q();
    endtask

    task automatic stop_c();
        sda_m = 1'b0; wait_q(); scl = 1'b1; wait_q();
        sda_m = 1'b1; wait_q(); wait_q();
    endtask

    task automatic put_bit(input bit b);
        sda_m = b; wait_q(); scl = 1'b1; wait_q(); wait_q(); scl = 1'b0; wait_q();
    endtask

    task automatic get_bit(output bit b);
        sda_m = 1'b1; wait_q(); scl = 1'b1; wait_q(); b = sda_line; wait_q(); scl = 1'b0; wait_q();
    endtask

    task automatic put_byte(input int v, output bit ack);
        bit a;
        for (int i = 7; i >= 0; i--) put_bit(1'((v >> i) & 1));
        get_bit(a);
        ack = !a;
    endtask

    task automatic get_byte(output int v, input bit mack);
        bit b;
        v = 0;
        for (int i = 0; i < 8; i++) begin
            get_bit(b);
            v = (v << 1) | int'(b);
        end
        put_bit(!mack);
    endtask

    task automatic byte_read(input int off, output int v, output bit ok);
        bit a1, a2, a3;
        cmp_en = 1'b0;
        start_c(); put_byte(8'hD2, a1); put_byte(8'h80 | off, a2);
        start_c(); put_byte(8'hD3, a3); get_byte(v, 1'b0); stop_c();
        ok = a1 & a2 & a3;
        cmp_en = 1'b1;
    endtask

    task automatic byte_write(input int off, input int v, output bit ok);
        bit a1, a2, a3;
        cmp_en = 1'b0;
        start_c(); put_byte(8'hD2, a1); put_byte(8'h80 | off, a2); put_byte(v, a3); stop_c();
        ok = a1 & a2 & a3;
        cmp_en = 1'b1;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        int v;
        bit ok, a;
        int bad_cmd [4] = '{8'hA0, 8'h86, 8'h01, 8'hC2};
        int run_vals [7] = '{8'h04, 8'h55, 8'h84, 8'h66, 8'h77, 8'h88, 8'h99};

        mdl = '{8'h3C, 8'h00, 8'hEB, 8'hAF, 8'h01, 8'h00};
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        wait_q();

        // R7: reset state
        chk({out_en, spread_en, spread_sel} == 3'b101, "R7 reset ctrl",
            int'({out_en, spread_en, spread_sel}), 5);
        chk(sda_oe == 1'b0, "R7 line released after reset", int'(sda_oe), 0);
        cmp_en = 1'b1;

        // R4 / R7: single-register reads of defaults
        byte_read(0, v, ok);
        chk(ok, "R4 read acks", int'(ok), 1);
        chk(v == 8'h3C, "R7 reg0 default (R4 read)", v, 8'h3C);
        byte_read(3, v, ok);
        chk(v == 8'hAF, "R7 reg3 default (R4 read)", v, 8'hAF);
        byte_read(4, v, ok);
        chk(v == 8'h01, "R7 reg4 default (R4 read)", v, 8'h01);

        // R3: single-register write, extra byte rejected
        cmp_en = 1'b0;
        start_c(); put_byte(8'hD2, a); put_byte(8'h82, a);
        put_byte(8'h04, a);
        chk(a, "R3 data ack", int'(a), 1);
        mdl[2] = 8'h04;
        put_byte(8'h5A, a);
        chk(!a, "R3 extra byte nack", int'(a), 0);
        stop_c();
        cmp_en = 1'b1;
        wait_q();
        chk(spread_en == 1'b1 && spread_sel == 1'b0, "R8 spread bits after write",
            int'({spread_en, spread_sel}), 2);
        byte_read(2, v, ok);
        chk(v == 8'h04, "R3 reg2 readback", v, 8'h04);
        byte_read(3, v, ok);
        chk(v == 8'hAF, "R3 neighbour untouched", v, 8'hAF);

        byte_write(0, 8'h00, ok);
        mdl[0] = 8'h00;
        chk(ok, "R3 write reg0 ack", int'(ok), 1);
        wait_q();
        chk(out_en == 1'b0, "R8 output enable off", int'(out_en), 0);

        // R6: run read
        cmp_en = 1'b0;
        start_c(); put_byte(8'hD2, a); put_byte(8'h00, a);
        chk(a, "R6 run command ack", int'(a), 1);
        start_c(); put_byte(8'hD3, a);
        get_byte(v, 1'b1);
        chk(v == 6, "R6 count byte", v, 6);
        for (int i = 0; i < 6; i++) begin
            get_byte(v, 1'b1);
            chk(v == mdl[i], "R6 run read register", v, mdl[i]);
        end
        get_byte(v, 1'b0);
        chk(v == 8'hFF, "R6 read past bank", v, 8'hFF);
        stop_c();
        cmp_en = 1'b1;

        // R5: short run write
        cmp_en = 1'b0;
        start_c(); put_byte(8'hD2, a); put_byte(8'h00, a);
        put_byte(8'h03, a);
        chk(a, "R5 count ack", int'(a), 1);
        put_byte(8'h11, a); put_byte(8'h22, a); put_byte(8'h33, a);
        chk(a, "R5 data ack", int'(a), 1);
        mdl[0] = 8'h11; mdl[1] = 8'h22; mdl[2] = 8'h33;
        stop_c();
        cmp_en = 1'b1;
        byte_read(1, v, ok);
        chk(v == 8'h22, "R5 reg1 after run write", v, 8'h22);

        // R5: run write running past the bank
        cmp_en = 1'b0;
        start_c(); put_byte(8'hD2, a); put_byte(8'h00, a); put_byte(8'h07, a);
        for (int i = 0; i < 6; i++) begin
            put_byte(run_vals[i], a);
            chk(a, "R5 in-bank data ack", int'(a), 1);
            mdl[i] = run_vals[i];
        end
        put_byte(run_vals[6], a);
        chk(!a, "R5 beyond bank nack", int'(a), 0);
        stop_c();
        cmp_en = 1'b1;
        byte_read(5, v, ok);
        chk(v == 8'h88, "R5 reg5 after full run", v, 8'h88);

        // R1: foreign addresses
        cmp_en = 1'b0;
        start_c(); put_byte(8'hD4, a);
        chk(!a, "R1 wrong write address nack", int'(a), 0);
        put_byte(8'h82, a);
        chk(!a, "R1 ignored after wrong address", int'(a), 0);
        put_byte(8'hFF, a);
        stop_c();
        start_c(); put_byte(8'hA1, a);
        chk(!a, "R1 wrong read address nack", int'(a), 0);
        get_byte(v, 1'b0);
        chk(v == 8'hFF, "R1 slave silent", v, 8'hFF);
        stop_c();
        cmp_en = 1'b1;

        // R2: rejected command codes
        for (int k = 0; k < 4; k++) begin
            cmp_en = 1'b0;
            start_c(); put_byte(8'hD2, a); put_byte(bad_cmd[k], a);
            chk(!a, "R2 bad command nack", bad_cmd[k], 0);
            put_byte(8'h00, a);
            chk(!a, "R2 following byte nack", int'(a), 0);
            stop_c();
            cmp_en = 1'b1;
        end
        byte_read(2, v, ok);
        chk(v == mdl[2], "R2 reg2 untouched", v, mdl[2]);

        // R9: start in the middle of a data byte
        cmp_en = 1'b0;
        start_c(); put_byte(8'hD2, a); put_byte(8'h81, a);
        for (int i = 0; i < 4; i++) put_bit(1'b0);
        start_c();
        chk(sda_oe == 1'b0, "R9 released after start", int'(sda_oe), 0);
        put_byte(8'hD2, a);
        chk(a, "R9 fresh address after start", int'(a), 1);
        stop_c();
        // R9: stop in the middle of a data byte
        start_c(); put_byte(8'hD2, a); put_byte(8'h81, a);
        for (int i = 0; i < 3; i++) put_bit(1'b0);
        stop_c();
        chk(sda_oe == 1'b0, "R9 released after stop", int'(sda_oe), 0);
        cmp_en = 1'b1;
        byte_read(1, v, ok);
        chk(v == mdl[1], "R9 aborted byte discarded", v, mdl[1]);

        wait_q();
        summary();
        $finish;
    end

endmodule